// File: doc/BRIEF.md
# EEPROM Write-Readback Test Sequencer

This block exercises a 2048-byte serial EEPROM from end to end. It splits the address space into chunks of a fixed, parameterised size. For each chunk it writes a known byte pattern, reads the same chunk back into its own buffer, and compares the two byte by byte. It then moves to the next chunk. When a full pass is complete it starts again at address zero, and it never stops.

The block does not drive the serial bus itself. It passes each transfer to a separate transaction master over a request/response handshake. A request carries the direction, an 11-bit byte address, a byte count and, for writes, the whole chunk of data. The master answers with a one-cycle completion strobe and a busy/reject flag. Any rejected transfer is issued again, without limit.

The block reports its results on one LED output. A short pulse follows each pass that had no mismatch. A long pulse follows each chunk that fails its compare, and testing carries on after it. Pulse lengths are counted on an external 1 ms tick. A mismatch counter and a completed-pass counter are also brought out as outputs.

Top module: `eeprom_sweep_tester`

## Requirements
- R1: While reset is high, and in the first cycle after it, req_valid and led are low and err_count and pass_count are zero.
- R2: Chunks are visited at addresses 0, C, 2C, ... where C is CHUNK_BYTES. Every request carries req_len equal to C. Address bits [10:8] hold the bank and bits [7:0] the byte within the bank, and a carry out of the low byte moves into the bank.
- R3: On a write request, byte i of req_wdata (bits 8i+7..8i) equals i+1, for i from 0 to C-1.
- R4: Each chunk gets exactly one successful write (req_write=1), followed by reads (req_write=0) of the same address. A read is issued only after the write has been accepted.
- R5: A completion with rsp_err=1 counts as a reject. After one idle cycle the identical request (same direction and address) is issued again, for as many rejects as occur. Data returned with a reject is ignored.
- R6: While req_valid is high and rsp_done is low, req_valid, req_write, req_addr and req_wdata hold their values. In the cycle after any rsp_done, req_valid is low.
- R7: A successful read whose data differs from the R3 pattern in any byte increments err_count by one and starts a long LED pulse of LONG_MS ticks. The sweep then continues with the next chunk.
- R8: When the next address would reach 2048, the pass ends: pass_count increments and the next chunk starts at address 0.
- R9: At the end of a pass in which no chunk miscompared, a short LED pulse of SHORT_MS ticks starts. A pass with any miscompare ends without a short pulse.
- R10: led goes high in the cycle after a pulse starts and stays high until the clock edge that consumes the Nth ms_tick pulse after the start, where N is that pulse's length. A tick in the start cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| req_valid | output | 1 | Transfer request to the master is pending |
| req_write | output | 1 | 1 = write chunk, 0 = read chunk |
| req_addr | output | 11 | Chunk byte address: bank in [10:8], byte in [7:0] |
| req_len | output | 5 | Number of bytes in the transfer |
| req_wdata | output | 8*CHUNK_BYTES | Write data, byte i in bits 8i+7..8i |
| rsp_done | input | 1 | One-cycle completion strobe from the master |
| rsp_err | input | 1 | Qualifies rsp_done: transfer rejected (device busy) |
| rsp_rdata | input | 8*CHUNK_BYTES | Read data, valid with rsp_done when rsp_err is low |
| led | output | 1 | Status LED |
| err_count | output | COUNT_W | Number of miscompared chunks so far |
| pass_count | output | COUNT_W | Number of completed passes |

## Verification
The bench builds the block with the default chunk of 8 bytes and cuts the LED lengths to 3 ticks (short) and 7 ticks (long), with a tick every 10 clocks. These values fit three complete 256-chunk passes into the run, with the bank carry and the wrap back to address 0 taken each time. Every LED pulse can be measured to the exact tick count, and it ends before the next event could restart it. A behavioural memory answers the requests with random latency and random busy rejects. It flips a byte on two reads in the second pass, one in mid-space and one in the final chunk. This shows that a miscompare in the final chunk suppresses the short pulse.

// File: rtl/eeprom_sweep_pkg.sv
package eeprom_sweep_pkg;

    localparam int ADDR_W      = 11;
    localparam int SPACE_BYTES = 1 << ADDR_W;
    localparam int LEN_W       = 5;

    typedef logic [ADDR_W-1:0] ee_addr_t;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_WRITE,
        ST_WR_RETRY,
        ST_RD_PREP,
        ST_READ,
        ST_RD_RETRY,
        ST_CHECK,
        ST_STEP
    } seq_state_t;

    // Known test pattern: byte index i carries value i+1.
    function automatic logic [7:0] pattern_byte(input int idx);
        return 8'(idx + 1);
    endfunction

endpackage

// File: rtl/sweep_addr_gen.sv
module sweep_addr_gen
    import eeprom_sweep_pkg::*;
#(
    parameter int STEP = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     advance,
    output ee_addr_t addr,
    output logic     last_chunk
);

    logic [ADDR_W:0] sum;

    // Carry out of the 11-bit add means the bank number would reach 8.
    assign sum        = {1'b0, addr} + (ADDR_W+1)'(STEP);
    assign last_chunk = sum[ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (advance) begin
            addr <= last_chunk ? '0 : sum[ADDR_W-1:0];
        end
    end

    assert_chunk_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(addr) % STEP) == 0);

endmodule

// File: rtl/chunk_checker.sv
module chunk_checker
    import eeprom_sweep_pkg::*;
#(
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               capture,
    input  logic [BYTES*8-1:0] rdata,
    output logic               mismatch
);

    logic [BYTES*8-1:0] rbuf;
    logic [BYTES-1:0]   byte_bad;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rbuf <= '0;
        end else if (capture) begin
            rbuf <= rdata;
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_cmp
        assign byte_bad[g] = (rbuf[g*8 +: 8] != pattern_byte(g));
    end

    assign mismatch = |byte_bad;

    // A freshly cleared buffer can never match a pattern of nonzero bytes.
    assert_cleared_fails_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> mismatch);

endmodule

// File: rtl/led_pulse_timer.sv
module led_pulse_timer #(
    parameter int SHORT_MS = 5,
    parameter int LONG_MS  = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start_short,
    input  logic start_long,
    output logic led
);

    localparam int MAX_MS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int W      = $clog2(MAX_MS + 1);

    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start_long) begin
            remain <= W'(LONG_MS);
        end else if (start_short) begin
            remain <= W'(SHORT_MS);
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign led = (remain != '0);

    assert_start_lights_R10: assert property (@(posedge clk) disable iff (rst)
        (start_long || start_short) |=> led);

    assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (led && !tick && !start_long && !start_short) |=> led);

endmodule

// File: rtl/eeprom_sweep_tester.sv
module eeprom_sweep_tester
    import eeprom_sweep_pkg::*;
#(
    parameter int CHUNK_BYTES = 8,
    parameter int SHORT_MS    = 5,
    parameter int LONG_MS     = 200,
    parameter int COUNT_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ms_tick,
    output logic                     req_valid,
    output logic                     req_write,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [LEN_W-1:0]         req_len,
    output logic [CHUNK_BYTES*8-1:0] req_wdata,
    input  logic                     rsp_done,
    input  logic                     rsp_err,
    input  logic [CHUNK_BYTES*8-1:0] rsp_rdata,
    output logic                     led,
    output logic [COUNT_W-1:0]       err_count,
    output logic [COUNT_W-1:0]       pass_count
);

    seq_state_t state, state_nx;
    logic       done_ok, done_bad;
    logic       mismatch, last_chunk, pass_dirty;
    logic       start_long, start_short, step_now;
    ee_addr_t   cur_addr;

    assign done_ok  = rsp_done && !rsp_err;
    assign done_bad = rsp_done && rsp_err;

    always_comb begin
        state_nx = state;
        case (state)
            ST_BOOT:     state_nx = ST_WRITE;
            ST_WRITE:    if (done_ok) state_nx = ST_RD_PREP;
                         else if (done_bad) state_nx = ST_WR_RETRY;
            ST_WR_RETRY: state_nx = ST_WRITE;
            ST_RD_PREP:  state_nx = ST_READ;
            ST_READ:     if (done_ok) state_nx = ST_CHECK;
                         else if (done_bad) state_nx = ST_RD_RETRY;
            ST_RD_RETRY: state_nx = ST_READ;
            ST_CHECK:    state_nx = ST_STEP;
            ST_STEP:     state_nx = ST_WRITE;
            default:     state_nx = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_BOOT;
        else     state <= state_nx;
    end

    assign start_long  = (state == ST_CHECK) && mismatch;
    assign step_now    = (state == ST_STEP);
    assign start_short = step_now && last_chunk && !pass_dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_count  <= '0;
            pass_count <= '0;
            pass_dirty <= 1'b0;
        end else begin
            if (start_long) begin
                err_count  <= err_count + 1'b1;
                pass_dirty <= 1'b1;
            end
            if (step_now && last_chunk) begin
                pass_count <= pass_count + 1'b1;
                pass_dirty <= 1'b0;
            end
        end
    end

    sweep_addr_gen #(.STEP(CHUNK_BYTES)) addr_i (
        .clk        (clk),
        .rst        (rst),
        .advance    (step_now),
        .addr       (cur_addr),
        .last_chunk (last_chunk)
    );

    chunk_checker #(.BYTES(CHUNK_BYTES)) check_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (state == ST_RD_PREP),
        .capture  ((state == ST_READ) && done_ok),
        .rdata    (rsp_rdata),
        .mismatch (mismatch)
    );

    led_pulse_timer #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) led_i (
        .clk         (clk),
        .rst         (rst),
        .tick        (ms_tick),
        .start_short (start_short),
        .start_long  (start_long),
        .led         (led)
    );

    assign req_valid = (state == ST_WRITE) || (state == ST_READ);
    assign req_write = (state == ST_WRITE);
    assign req_addr  = cur_addr;
    assign req_len   = LEN_W'(CHUNK_BYTES);

    for (genvar g = 0; g < CHUNK_BYTES; g++) begin : g_pat
        assign req_wdata[g*8 +: 8] = pattern_byte(g);
    end

    assert_gap_after_done_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_done) |=> !req_valid);

    assert_hold_request_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_done) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

    assert_retry_same_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_done && rsp_err) |=> ##1
        (req_valid && req_write == $past(req_write, 2) && req_addr == $past(req_addr, 2)));

    assert_error_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (err_count != $past(err_count)) |-> led);

    assert_pass_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (pass_count != $past(pass_count)) |-> (req_addr == '0));

endmodule

// File: tb/eeprom_sweep_tester_tb.sv
module eeprom_sweep_tester_tb_top;
    import eeprom_sweep_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CHUNK      = 8;
    localparam int SHORT_T    = 3;
    localparam int LONG_T     = 7;
    localparam int TICK_DIV   = 10;
    localparam int CW         = 16;
    localparam int WATCHDOG   = 150000;
    localparam int PASSES     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic rsp_done = 1'b0;
    logic rsp_err = 1'b0;
    logic [CHUNK*8-1:0] rsp_rdata = '0;

    logic               req_valid, req_write, led;
    logic [ADDR_W-1:0]  req_addr;
    logic [LEN_W-1:0]   req_len;
    logic [CHUNK*8-1:0] req_wdata;
    logic [CW-1:0]      err_count, pass_count;

    eeprom_sweep_tester #(
        .CHUNK_BYTES(CHUNK), .SHORT_MS(SHORT_T), .LONG_MS(LONG_T), .COUNT_W(CW)
    ) dut_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .led(led), .err_count(err_count), .pass_count(pass_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [SPACE_BYTES];
    int  exp_addr = 0;
    bit  exp_write = 1'b1;
    bit  prev_rej = 1'b0;
    int  passes_done = 0;
    bit  dirty = 1'b0;
    int  exp_err = 0;
    int  exp_led = 0;
    int  exp_pulses = 0;
    int  seen_pulses = 0;
    bit  finished = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [CHUNK*8-1:0] exp_pattern();
        logic [CHUNK*8-1:0] w;
        for (int i = 0; i < CHUNK; i++) w[i*8 +: 8] = 8'(i + 1);
        return w;
    endfunction

    // Tick generator
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    // LED pulse monitor (R7 long, R9 short, R10 length)
    initial begin
        bit prev_led = 1'b0;
        int ticks = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) continue;
            if (led && ms_tick) ticks++;
            if (prev_led && !led) begin
                seen_pulses++;
                check("R10", "led pulse length in ticks", 128'(ticks), 128'(exp_led));
                ticks = 0;
            end
            prev_led = led;
        end
    end

    // Behavioural transaction master with memory, busy rejects and faults
    initial begin
        int  dly;
        bit  rej, fault;
        logic [ADDR_W-1:0]  h_addr;
        logic               h_write;
        for (int i = 0; i < SPACE_BYTES; i++) mem[i] = 8'hFF;
        void'($urandom(32'd20240611));
        wait (!rst);
        while (!finished) begin
            @(negedge clk);
            if (!req_valid) continue;
            check(prev_rej ? "R5" : "R4", "request direction", 128'(req_write), 128'(exp_write));
            check("R2", "request address", 128'(req_addr), 128'(exp_addr));
            check("R2", "request length", 128'(req_len), 128'(CHUNK));
            if (req_write) begin
                check("R3", "write pattern", 128'(req_wdata), 128'(exp_pattern()));
                check("R7", "err_count before chunk", 128'(err_count), 128'(exp_err));
                check("R8", "pass_count before chunk", 128'(pass_count), 128'(passes_done));
            end
            h_addr  = req_addr;
            h_write = req_write;
            dly = $urandom_range(0, 2);
            for (int k = 0; k < dly; k++) begin
                @(negedge clk);
                check("R6", "request held", 128'({req_valid, req_write, req_addr}),
                      128'({1'b1, h_write, h_addr}));
            end
            rej   = ($urandom_range(0, 3) == 0);
            fault = (passes_done == 1) && (exp_addr == 1016 || exp_addr == 2040);
            rsp_done = 1'b1;
            rsp_err  = rej;
            if (h_write) begin
                rsp_rdata = '0;
                if (!rej) for (int i = 0; i < CHUNK; i++) mem[int'(h_addr) + i] = req_wdata[i*8 +: 8];
            end else if (rej) begin
                rsp_rdata = {$urandom(), $urandom()};
            end else begin
                for (int i = 0; i < CHUNK; i++) rsp_rdata[i*8 +: 8] = mem[int'(h_addr) + i];
                if (fault) rsp_rdata[7:0] = rsp_rdata[7:0] ^ 8'h5A;
            end
            @(negedge clk);
            rsp_done = 1'b0;
            rsp_err  = 1'b0;
            check("R6", "idle after completion", 128'(req_valid), 128'(0));
            prev_rej = rej;
            if (!rej) begin
                if (h_write) begin
                    exp_write = 1'b0;
                end else begin
                    exp_write = 1'b1;
                    if (fault) begin
                        dirty = 1'b1;
                        exp_err++;
                        exp_led = LONG_T;
                        exp_pulses++;
                    end
                    if (exp_addr + CHUNK >= SPACE_BYTES) begin
                        passes_done++;
                        if (!dirty) begin
                            exp_led = SHORT_T;
                            exp_pulses++;
                        end
                        dirty = 1'b0;
                        exp_addr = 0;
                    end else begin
                        exp_addr += CHUNK;
                    end
                end
            end
            if (passes_done == PASSES) begin
                repeat (120) @(negedge clk);
                check("R8", "final pass_count", 128'(pass_count), 128'(PASSES));
                check("R7", "final err_count", 128'(err_count), 128'(2));
                check("R9", "led pulse count", 128'(seen_pulses), 128'(exp_pulses));
                check("R9", "expected pulse count", 128'(exp_pulses), 128'(4));
                finished = 1'b1;
            end
        end
    end

    // Reset, watchdog and summary
    initial begin
        int cyc = 0;
        repeat (2) @(negedge clk);
        check("R1", "req_valid in reset", 128'(req_valid), 128'(0));
        check("R1", "led in reset", 128'(led), 128'(0));
        check("R1", "counters in reset", 128'({err_count, pass_count}), 128'(0));
        rst = 1'b0;
        #1;
        check("R1", "req_valid after reset", 128'(req_valid), 128'(0));
        while (!finished && cyc < WATCHDOG) begin
            @(negedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule